// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block decides, once per clock, which warp of a compute core may send its next instruction into an execution pipe. The warps it supervises sit in one of two ordered pools. The active pool is small and has a configurable cap. The pending pool holds every other warp. Only warps in the active pool can issue. A warp that stalls on a long-latency load, or is otherwise waiting, is moved out to make room for a warp that is ready. This keeps the working set small, so warps reach their long loads at staggered times.

Each cycle runs in three steps, decided from the pool contents as they stood when the cycle began. First, at most one stalled active warp is demoted to the tail of the pending pool. Next, if the active pool then has room, at most one non-waiting pending warp is promoted to the tail of the active pool. Last, the active pool is scanned in order and the first warp able to issue is granted. That warp moves to the active tail, which rotates priority. Warps join the scheduler through an add port and always land at the pending tail. Pool state is updated on each rising clock edge. Grants and flush requests are combinational from the current pools and the per-warp inputs.

Top module: `tls_two_level_sched`

## Requirements
- R1: Reset empties both pools. No grant is asserted while the active pool is empty, and no flush bit is set then.
- R2: A warp presented on the add port is placed at the pending tail. The soonest it can be granted is two cycles after the edge that accepted it: one cycle to be promoted, one to be granted.
- R3: Each cycle, the first active warp (in pool order) whose waiting flag or long-load dependency flag is set is removed and appended to the pending tail. At most one warp is demoted per cycle, and a demoted warp is not granted in that cycle.
- R4: If the active count minus any demotion is below the cap, the first pending warp (in pool order) with its waiting flag clear is appended to the active tail. At most one warp is promoted per cycle. A promoted warp cannot be granted before the following cycle.
- R5: The grant goes to the first active warp able to issue. On the next edge that warp moves to the active tail. When both a promotion and a grant happen in one cycle, the promoted warp is placed just ahead of the granted warp at the tail.
- R6: An instruction of class memory (code 3) is granted only on the memory pipe (pipe code 3), and only while mem_free is high.
- R7: Class SP (code 0) is granted on the SP pipe (pipe code 1) when sp_free is high. Class SFU (code 2) is granted on the SFU pipe (pipe code 2) when sfu_free is high. Class dual (code 1) takes the SP pipe if sp_free is high, otherwise the SFU pipe if sfu_free is high. Pipe code 0 means no pipe.
- R8: A live active warp whose instruction PC differs from its reconvergence PC is not granted. Its bit in flush_req is set instead, provided it lies ahead of the granted warp in the scan, or no warp is granted.
- R9: A warp whose hazard flag from the scoreboard is set is skipped, and the scan continues with the next active warp.
- R10: The active pool never holds more than CAP warps.
- R11: A warp that is waiting, has an empty instruction buffer, or has no valid decoded instruction is neither granted nor flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Add a warp to the scheduler this cycle |
| add_wid | input | $clog2(NW) | ID of the warp being added |
| w_wait | input | NW | Per-warp waiting flag |
| w_longdep | input | NW | Per-warp flag: next instruction reads a register fed by a long-latency load |
| w_hazard | input | NW | Per-warp scoreboard collision with pending writes |
| ib_empty | input | NW | Per-warp instruction buffer empty |
| ib_valid | input | NW | Per-warp next buffered instruction is valid |
| ins_class | input | NW x 2 | Per-warp instruction class (0 SP, 1 dual, 2 SFU, 3 memory) |
| ins_pc | input | NW x PCW | Per-warp PC of the next buffered instruction |
| stk_pc | input | NW x PCW | Per-warp PC at the top of the reconvergence stack |
| sp_free | input | 1 | SP pipe can accept an instruction |
| sfu_free | input | 1 | SFU pipe can accept an instruction |
| mem_free | input | 1 | Memory pipe can accept an instruction |
| iss_valid | output | 1 | A warp is granted issue this cycle |
| iss_wid | output | $clog2(NW) | Granted warp ID |
| iss_pipe | output | 2 | Pipe of the grant (1 SP, 2 SFU, 3 memory) |
| flush_req | output | NW | Per-warp request to flush the buffer and reload the PC from the stack |

## Verification
The bench fills the pending pool with waiting warps, then releases them. The first grant must appear exactly two cycles later. Only the first CAP warps may then rotate. A scheduler that put new warps straight into the active pool would grant one cycle early. One that ignored the cap would let a fifth warp issue. Demotion and promotion are tested together with several waiting warps. The bench checks that the promoted warp skips waiting pending entries, and that a demoted warp comes back only after it has crossed the pending pool. Wrong ordering, or more than one move per cycle, would change the granted sequence. Pipe selection is tested with each pipe busy in turn, including a dual-class instruction falling back to the SFU pipe. Hazard, PC mismatch and empty-buffer cases must let the scan pass to the next warp, with flush bits only ahead of the grant.

// File: rtl/tls_pkg.sv
package tls_pkg;

    typedef enum logic [1:0] {
        PIPE_NONE = 2'd0,
        PIPE_SP   = 2'd1,
        PIPE_SFU  = 2'd2,
        PIPE_MEM  = 2'd3
    } pipe_e;

    typedef enum logic [1:0] {
        CL_SP   = 2'd0,
        CL_DUAL = 2'd1,
        CL_SFU  = 2'd2,
        CL_MEM  = 2'd3
    } iclass_e;

endpackage

// File: rtl/tls_first_hit.sv
// Finds the first entry, in pool order, whose warp has its flag bit set.
module tls_first_hit #(
    parameter int DEPTH = 4,
    parameter int NW    = 8,
    parameter int IDW   = 3,
    parameter int CW    = 4,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][IDW-1:0] list,
    input  logic [CW-1:0]             cnt,
    input  logic                      skip_en,
    input  logic [PW-1:0]             skip_pos,
    input  logic [NW-1:0]             flag,
    output logic                      hit,
    output logic [PW-1:0]             pos
);

    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if ((CW'(k) < cnt) && !(skip_en && (PW'(k) == skip_pos)) &&
                flag[list[k]]) begin
                hit = 1'b1;
                pos = PW'(k);
            end
        end
    end

endmodule

// File: rtl/tls_warp_eval.sv
// Per-warp readiness, flush candidacy and pipe selection.
module tls_warp_eval
    import tls_pkg::*;
#(
    parameter int NW  = 8,
    parameter int PCW = 16
) (
    input  logic [NW-1:0]           w_wait,
    input  logic [NW-1:0]           w_hazard,
    input  logic [NW-1:0]           ib_empty,
    input  logic [NW-1:0]           ib_valid,
    input  logic [NW-1:0][1:0]      ins_class,
    input  logic [NW-1:0][PCW-1:0]  ins_pc,
    input  logic [NW-1:0][PCW-1:0]  stk_pc,
    input  logic                    sp_free,
    input  logic                    sfu_free,
    input  logic                    mem_free,
    output logic [NW-1:0]           can_iss,
    output logic [NW-1:0]           want_flush,
    output logic [NW-1:0][1:0]      pipe_sel
);

    for (genvar g = 0; g < NW; g++) begin : g_warp
        logic  live;
        logic  pc_ok;
        pipe_e psel;

        assign live  = !w_wait[g] && !ib_empty[g] && ib_valid[g];
        assign pc_ok = (ins_pc[g] == stk_pc[g]);

        always_comb begin
            unique case (iclass_e'(ins_class[g]))
                CL_MEM:  psel = mem_free ? PIPE_MEM : PIPE_NONE;
                CL_SP:   psel = sp_free  ? PIPE_SP  : PIPE_NONE;
                CL_SFU:  psel = sfu_free ? PIPE_SFU : PIPE_NONE;
                CL_DUAL: psel = sp_free  ? PIPE_SP  :
                                (sfu_free ? PIPE_SFU : PIPE_NONE);
                default: psel = PIPE_NONE;
            endcase
        end

        assign pipe_sel[g]   = psel;
        assign want_flush[g] = live && !pc_ok;
        assign can_iss[g]    = live && pc_ok && !w_hazard[g] && (psel != PIPE_NONE);
    end

endmodule

// File: rtl/tls_two_level_sched.sv
module tls_two_level_sched
    import tls_pkg::*;
#(
    parameter int NW  = 8,
    parameter int CAP = 4,
    parameter int PCW = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                add_valid,
    input  logic [((NW > 1) ? $clog2(NW) : 1)-1:0] add_wid,
    input  logic [NW-1:0]                       w_wait,
    input  logic [NW-1:0]                       w_longdep,
    input  logic [NW-1:0]                       w_hazard,
    input  logic [NW-1:0]                       ib_empty,
    input  logic [NW-1:0]                       ib_valid,
    input  logic [NW-1:0][1:0]                  ins_class,
    input  logic [NW-1:0][PCW-1:0]              ins_pc,
    input  logic [NW-1:0][PCW-1:0]              stk_pc,
    input  logic                                sp_free,
    input  logic                                sfu_free,
    input  logic                                mem_free,
    output logic                                iss_valid,
    output logic [((NW > 1) ? $clog2(NW) : 1)-1:0] iss_wid,
    output logic [1:0]                          iss_pipe,
    output logic [NW-1:0]                       flush_req
);

    localparam int IDW = (NW > 1)  ? $clog2(NW)  : 1;
    localparam int CW  = $clog2(NW + 1);
    localparam int APW = (CAP > 1) ? $clog2(CAP) : 1;
    localparam int PPW = (NW > 1)  ? $clog2(NW)  : 1;

    // pool state
    logic [CAP-1:0][IDW-1:0] act_q, act_nx;
    logic [CW-1:0]           act_n, act_n_nx;
    logic [NW-1:0][IDW-1:0]  pend_q, pend_nx;
    logic [CW-1:0]           pend_n, pend_n_nx;

    // per-warp evaluation
    logic [NW-1:0]      can_iss, want_flush;
    logic [NW-1:0][1:0] pipe_sel;

    tls_warp_eval #(.NW(NW), .PCW(PCW)) u_eval (
        .w_wait(w_wait), .w_hazard(w_hazard), .ib_empty(ib_empty),
        .ib_valid(ib_valid), .ins_class(ins_class), .ins_pc(ins_pc),
        .stk_pc(stk_pc), .sp_free(sp_free), .sfu_free(sfu_free),
        .mem_free(mem_free), .can_iss(can_iss), .want_flush(want_flush),
        .pipe_sel(pipe_sel)
    );

    // step 1: demotion pick
    logic           dem_hit;
    logic [APW-1:0] dem_pos;
    tls_first_hit #(.DEPTH(CAP), .NW(NW), .IDW(IDW), .CW(CW), .PW(APW)) u_dem (
        .list(act_q), .cnt(act_n), .skip_en(1'b0), .skip_pos('0),
        .flag(w_wait | w_longdep), .hit(dem_hit), .pos(dem_pos)
    );

    // step 2: promotion pick
    logic           prm_hit;
    logic [PPW-1:0] prm_pos;
    logic           prm_go;
    tls_first_hit #(.DEPTH(NW), .NW(NW), .IDW(IDW), .CW(CW), .PW(PPW)) u_prm (
        .list(pend_q), .cnt(pend_n), .skip_en(1'b0), .skip_pos('0),
        .flag(~w_wait), .hit(prm_hit), .pos(prm_pos)
    );
    assign prm_go = prm_hit && ((act_n - CW'(dem_hit)) < CW'(CAP));

    // step 3: issue pick over the active pool, demoted slot excluded
    logic           iss_hit;
    logic [APW-1:0] iss_pos;
    tls_first_hit #(.DEPTH(CAP), .NW(NW), .IDW(IDW), .CW(CW), .PW(APW)) u_iss (
        .list(act_q), .cnt(act_n), .skip_en(dem_hit), .skip_pos(dem_pos),
        .flag(can_iss), .hit(iss_hit), .pos(iss_pos)
    );

    assign iss_valid = iss_hit;
    assign iss_wid   = act_q[iss_pos];
    assign iss_pipe  = iss_hit ? pipe_sel[iss_wid] : PIPE_NONE;

    // flush requests for live mismatched warps scanned before the grant
    always_comb begin
        flush_req = '0;
        for (int k = 0; k < CAP; k++) begin
            if ((CW'(k) < act_n) && !(dem_hit && (APW'(k) == dem_pos)) &&
                (!iss_hit || (APW'(k) < iss_pos)) && want_flush[act_q[k]]) begin
                flush_req[act_q[k]] = 1'b1;
            end
        end
    end

    // next active pool: survivors, then promoted, then granted
    always_comb begin
        int j;
        j      = 0;
        act_nx = '0;
        for (int k = 0; k < CAP; k++) begin
            if ((CW'(k) < act_n) && !(dem_hit && (APW'(k) == dem_pos)) &&
                !(iss_hit && (APW'(k) == iss_pos))) begin
                if (j < CAP) act_nx[APW'(j)] = act_q[k];
                j++;
            end
        end
        if (prm_go) begin
            if (j < CAP) act_nx[APW'(j)] = pend_q[prm_pos];
            j++;
        end
        if (iss_hit) begin
            if (j < CAP) act_nx[APW'(j)] = iss_wid;
            j++;
        end
        act_n_nx = CW'(j);
    end

    // next pending pool: survivors, then demoted, then newly added
    always_comb begin
        int j;
        j       = 0;
        pend_nx = '0;
        for (int k = 0; k < NW; k++) begin
            if ((CW'(k) < pend_n) && !(prm_go && (PPW'(k) == prm_pos))) begin
                if (j < NW) pend_nx[PPW'(j)] = pend_q[k];
                j++;
            end
        end
        if (dem_hit) begin
            if (j < NW) pend_nx[PPW'(j)] = act_q[dem_pos];
            j++;
        end
        if (add_valid) begin
            if (j < NW) pend_nx[PPW'(j)] = add_wid;
            j++;
        end
        pend_n_nx = CW'(j);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            act_n  <= '0;
            pend_q <= '0;
            pend_n <= '0;
        end else begin
            act_q  <= act_nx;
            act_n  <= act_n_nx;
            pend_q <= pend_nx;
            pend_n <= pend_n_nx;
        end
    end

    // ---------------- assertions ----------------
    logic [IDW-1:0] tail_wid;
    assign tail_wid = act_q[APW'(act_n - CW'(1))];

    a_r10_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
        act_n <= CW'(CAP));

    a_r1_no_grant_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (act_n == '0) |-> (!iss_valid && (flush_req == '0)));

    a_r5_granted_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (act_n != '0) && (tail_wid == $past(iss_wid)));

    a_r2_warp_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, act_n} + {1'b0, pend_n}) ==
                 ($past({1'b0, act_n} + {1'b0, pend_n}) + (CW+1)'($past(add_valid))));

    a_r6_mem_pipe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (ins_class[iss_wid] == CL_MEM)) |-> (mem_free && (iss_pipe == PIPE_MEM)));

    a_r7_sp_pipe_free: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_pipe == PIPE_SP)) |-> sp_free);

    a_r7_sfu_pipe_free: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_pipe == PIPE_SFU)) |-> sfu_free);

    a_r8_no_flush_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !flush_req[iss_wid]);

    a_r9_no_grant_on_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (!w_hazard[iss_wid] && !w_wait[iss_wid] && !w_longdep[iss_wid] ||
                       !w_hazard[iss_wid] && !w_wait[iss_wid]));

    a_r11_no_grant_empty_buf: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (!ib_empty[iss_wid] && ib_valid[iss_wid]));

endmodule

// File: tb/tb_tls_two_level_sched.sv
module tb_tls_two_level_sched;

    localparam int NW  = 8;
    localparam int CAP = 4;
    localparam int PCW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 add_valid;
    logic [2:0]           add_wid;
    logic [NW-1:0]        w_wait, w_longdep, w_hazard, ib_empty, ib_valid;
    logic [NW-1:0][1:0]   ins_class;
    logic [NW-1:0][PCW-1:0] ins_pc, stk_pc;
    logic                 sp_free, sfu_free, mem_free;
    logic                 iss_valid;
    logic [2:0]           iss_wid;
    logic [1:0]           iss_pipe;
    logic [NW-1:0]        flush_req;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tls_two_level_sched #(.NW(NW), .CAP(CAP), .PCW(PCW)) dut (
        .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .add_wid(add_wid),
        .w_wait(w_wait), .w_longdep(w_longdep), .w_hazard(w_hazard),
        .ib_empty(ib_empty), .ib_valid(ib_valid), .ins_class(ins_class),
        .ins_pc(ins_pc), .stk_pc(stk_pc), .sp_free(sp_free),
        .sfu_free(sfu_free), .mem_free(mem_free), .iss_valid(iss_valid),
        .iss_wid(iss_wid), .iss_pipe(iss_pipe), .flush_req(flush_req)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_iss(string tag, bit ev, int ew, int ep);
        #1;
        nchk++;
        if (iss_valid !== ev || (ev && (iss_wid !== 3'(ew) || iss_pipe !== 2'(ep)))) begin
            nfail++;
            $display("FAIL %s: grant valid=%0b wid=%0d pipe=%0d, expected valid=%0b wid=%0d pipe=%0d",
                     tag, iss_valid, iss_wid, iss_pipe, ev, ew, ep);
        end
    endtask

    task automatic chk_flush(string tag, logic [NW-1:0] exp);
        #1;
        nchk++;
        if (flush_req !== exp) begin
            nfail++;
            $display("FAIL %s: flush_req=%b expected %b", tag, flush_req, exp);
        end
    endtask

    task automatic defaults();
        add_valid = 1'b0; add_wid = '0;
        w_wait = '0; w_longdep = '0; w_hazard = '0;
        ib_empty = '0; ib_valid = '1;
        sp_free = 1'b1; sfu_free = 1'b1; mem_free = 1'b1;
        for (int i = 0; i < NW; i++) begin
            ins_class[i] = 2'd0;
            ins_pc[i]    = PCW'(i * 4);
            stk_pc[i]    = PCW'(i * 4);
        end
    endtask

    // R1: pools empty after reset, nothing granted
    task automatic t_reset();
        defaults();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        chk_iss("R1 reset state", 1'b0, 0, 0);
        chk_flush("R1 reset flush", '0);
    endtask

    // R2: all warps added as waiting stay pending, no grant
    task automatic t_fill();
        w_wait = '1;
        for (int i = 0; i < NW; i++) begin
            add_valid = 1'b1;
            add_wid   = 3'(i);
            chk_iss("R1 R2 fill no grant", 1'b0, 0, 0);
            cyc();
        end
        add_valid = 1'b0;
    endtask

    // R2 R4 R5 R10: release, promote one per cycle, rotate within cap
    task automatic t_rotate();
        int exp_seq[8] = '{-1, 0, 1, 0, 2, 1, 3, 0};
        w_wait = '0;
        for (int i = 0; i < 8; i++) begin
            if (exp_seq[i] < 0) chk_iss("R2 R4 promotion latency", 1'b0, 0, 0);
            else chk_iss("R5 R10 rotation order", 1'b1, exp_seq[i], 1);
            cyc();
        end
    endtask

    // R9: hazard skips to the next warp
    task automatic t_hazard();
        w_hazard[2] = 1'b1;
        chk_iss("R9 hazard skip", 1'b1, 1, 1);
        cyc();
        w_hazard = '0;
    endtask

    // R8: PC mismatch flushes and the scan continues
    task automatic t_flush();
        stk_pc[2] = ins_pc[2] + PCW'(1);
        chk_iss("R8 mismatch not granted", 1'b1, 3, 1);
        chk_flush("R8 flush bit", 8'h04);
        cyc();
        stk_pc[2] = ins_pc[2];
    endtask

    // R6: memory class needs the memory pipe
    task automatic t_mem();
        ins_class[2] = 2'd3;
        mem_free = 1'b0;
        chk_iss("R6 mem pipe busy", 1'b1, 0, 1);
        cyc();
        mem_free = 1'b1;
        chk_iss("R6 mem pipe grant", 1'b1, 2, 3);
        cyc();
        ins_class[2] = 2'd0;
    endtask

    // R7: SP/SFU/dual pipe selection
    task automatic t_pipes();
        ins_class[1] = 2'd1;
        sp_free = 1'b0;
        chk_iss("R7 dual falls to SFU", 1'b1, 1, 2);
        cyc();
        sfu_free = 1'b0;
        chk_iss("R7 no pipe free", 1'b0, 0, 0);
        cyc();
        sp_free = 1'b1;
        ins_class[3] = 2'd2;
        ins_class[0] = 2'd1;
        chk_iss("R7 SFU busy dual to SP", 1'b1, 0, 1);
        cyc();
        for (int i = 0; i < NW; i++) ins_class[i] = 2'd0;
        sfu_free = 1'b1;
    endtask

    // R3 R4: long-load dependency demotes, pending head promoted
    task automatic t_longdep();
        w_longdep[2] = 1'b1;
        chk_iss("R3 demoted warp skipped", 1'b1, 3, 1);
        cyc();
        w_longdep = '0;
        chk_iss("R3 after demotion", 1'b1, 1, 1);
        cyc();
        chk_iss("R3 after demotion", 1'b1, 0, 1);
        cyc();
        chk_iss("R4 promoted warp issues", 1'b1, 4, 1);
        cyc();
    endtask

    // R3 R4: one demotion per cycle, promotion skips waiting pending warps
    task automatic t_waiting();
        w_wait = 8'b0110_1010;
        chk_iss("R3 one demotion", 1'b1, 0, 1);
        cyc();
        chk_iss("R4 skip waiting pending", 1'b1, 4, 1);
        cyc();
        chk_iss("R4 promoted order", 1'b1, 7, 1);
        cyc();
        chk_iss("R5 rotation", 1'b1, 0, 1);
        cyc();
        chk_iss("R3 demoted returns via pending tail", 1'b1, 2, 1);
        cyc();
        w_wait = '0;
    endtask

    // R11: empty or invalid buffers are neither granted nor flushed
    task automatic t_buffers();
        ib_empty[4] = 1'b1;
        ib_empty[7] = 1'b1;
        ib_valid[0] = 1'b0;
        chk_iss("R11 skip empty/invalid", 1'b1, 2, 1);
        cyc();
        ib_valid[2] = 1'b0;
        chk_iss("R11 nothing live", 1'b0, 0, 0);
        chk_flush("R11 no flush", '0);
        cyc();
        ib_empty = '0;
        ib_valid = '1;
    endtask

    // R1: reset mid-run clears pools
    task automatic t_reset_again();
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        chk_iss("R1 reset mid-run", 1'b0, 0, 0);
        cyc();
        chk_iss("R1 pools stay empty", 1'b0, 0, 0);
        chk_flush("R1 no flush after reset", '0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_rotate();
        t_hazard();
        t_flush();
        t_mem();
        t_pipes();
        t_longdep();
        t_waiting();
        t_buffers();
        t_reset_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule